// File: doc/BRIEF.md
# PHY Management Register Front-End

This block sits on the register bus of an Ethernet MAC and stands in for a PHY's management interface. Software writes a PHY register number into an address register. It then starts a read by raising the read bit of a command register, or starts a write by writing data into a write-data register. A small on-chip PHY model answers these accesses. It holds a control word and a status word, and it returns fixed words for a few register numbers. Read results land in a read-data register that software fetches over the same bus.

The bus has a write strobe, a 3-bit register index, 32-bit write data and combinational read data. Reading a register over the bus has no side effects. A three-state sequencer turns bus writes into PHY operations. From `S_IDLE`, the transition *start-read* (a write to the command register whose bit 0 goes from 0 to 1) enters `S_READ`. The transition *start-write* (any write to the write-data register) enters `S_WRITE`. In `S_READ` the read-data register is loaded, and in `S_WRITE` the PHY model is updated. Each of those states lasts exactly one clock. It leaves through *start-read* or *start-write* again if a new command arrives in that clock, and otherwise through *done* back to `S_IDLE`. The sequencer captures the PHY register number when the operation starts.

Bus register map (index: access): 0 command (read-write, bit 0 = read request), 1 address (read-write, bits 4:0 = PHY register number, bits 12:8 = PHY address), 2 write-data (read-write, low 16 bits kept), 3 read-data (read-only, loaded by reads), 4 scratch (read-write), 5 write-only latch (read back as stored), 6 link event (write-one-to-clear), 7 reserved (read-only, reads 0).

Top module: `phy_mgmt_front`

## Requirements
- R1: After reset every bus register (indices 0 to 7) reads 0.
- R2: A PHY read starts only when a write to index 0 has bit 0 set while the stored bit 0 is 0. Writing a 1 over a stored 1 starts nothing. Index 0 always stores the written value.
- R3: The clock after a read starts, index 3 holds the PHY word of the selected register number in its low 16 bits. Number 0 gives the PHY control word, number 1 the PHY status word, number 10 gives 0x1800, and any other number gives 0. Index 3 then holds that value until the next read.
- R4: The PHY register number is address bits 4:0. The PHY address field (bits 12:8) has no effect on which register responds.
- R5: A write to index 2 stores only its low 16 bits (bits 31:16 read 0). The write always starts a PHY write, which completes the next clock.
- R6: A PHY write to register number 0 stores the data with bits 15 and 8 cleared. A PHY write to any other number changes nothing.
- R7: The PHY status word is 0x7809 with bit 2 equal to the link-up input at the time of the read (0x780D when the link is up).
- R8: Indices 4 (read-write) and 5 (write-only) take the full 32-bit written value.
- R9: Bit 0 of index 6 sets on the clock after the link-up input changes. A write to index 6 clears each bit written as 1, and bits written as 0 are unchanged. A set in the same clock wins over a clear.
- R10: Bus writes to the read-only indices 3 and 7 change nothing.
- R11: A new command accepted in the clock in which a previous PHY operation completes is not lost. Reads and writes complete in bus order, so a read right after a write returns the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_idx | input | 3 | Register index for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of register `bus_idx` |
| link_up | input | 1 | Link state reported by the PHY side |

## Verification
The hardest situation to reach is a command that lands while the sequencer is still in `S_READ` or `S_WRITE`. For that to happen, the write-data write and the command's 0-to-1 edge must fall on consecutive clocks, with the command bit already lowered one clock earlier. The bench drives exactly that back-to-back pattern and then reads the result. A random phase then issues bus operations every clock, with the address field biased toward the answering register numbers and occasional link flips. A behavioural model tracks pending operations and compares every register read on every clock.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    typedef enum logic [1:0] {
        ACC_RW,
        ACC_WO,
        ACC_W1C,
        ACC_RO
    } acc_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE
    } seq_state_e;

    localparam int unsigned IDX_CMD     = 0;
    localparam int unsigned IDX_ADDR    = 1;
    localparam int unsigned IDX_WDATA   = 2;
    localparam int unsigned IDX_RDATA   = 3;
    localparam int unsigned IDX_SCRATCH = 4;
    localparam int unsigned IDX_WONLY   = 5;
    localparam int unsigned IDX_EVENT   = 6;
    localparam int unsigned IDX_RSVD    = 7;

    // access type of each bus register index
    function automatic acc_e acc_of(input int unsigned i);
        case (i)
            IDX_CMD, IDX_ADDR, IDX_WDATA, IDX_SCRATCH: return ACC_RW;
            IDX_WONLY:                                 return ACC_WO;
            IDX_EVENT:                                 return ACC_W1C;
            default:                                   return ACC_RO;
        endcase
    endfunction

endpackage

// File: rtl/mgmt_regbank.sv
module mgmt_regbank
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned NREG   = 8,
    parameter int unsigned DW     = 32,
    parameter int unsigned KEEP_W = 16,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IDX_W-1:0]         idx,
    input  logic [DW-1:0]            wdata,
    input  logic                     ld_en,
    input  logic [DW-1:0]            ld_val,
    input  logic [DW-1:0]            set_bits,
    output logic [NREG-1:0][DW-1:0]  regs_o
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam acc_e ACC = acc_of(i);
        localparam logic [DW-1:0] KEEP =
            (i == IDX_WDATA) ? {{(DW-KEEP_W){1'b0}}, {KEEP_W{1'b1}}} : {DW{1'b1}};
        logic hit;
        assign hit = we && (idx == IDX_W'(i));

        if (ACC == ACC_W1C) begin : g_w1c
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= (q & ~(hit ? wdata : '0)) | set_bits;
            end
            assign regs_o[i] = q;
        end else if (ACC == ACC_RO) begin : g_ro
            if (i == IDX_RDATA) begin : g_load
                logic [DW-1:0] q;
                always_ff @(posedge clk) begin
                    if (!rst_n)     q <= '0;
                    else if (ld_en) q <= ld_val;
                end
                assign regs_o[i] = q;
            end else begin : g_zero
                assign regs_o[i] = '0;
            end
        end else begin : g_rw
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= '0;
                else if (hit) q <= wdata & KEEP;
            end
            assign regs_o[i] = q;
        end
    end

endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned IDX_W = 3,
    parameter int unsigned FW    = 5,
    parameter int unsigned PW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic             rd_bit_new,
    input  logic             rd_bit_old,
    input  logic [PW-1:0]    wr_val,
    input  logic [FW-1:0]    preg_in,
    output logic             rd_go,
    output logic             wr_go,
    output logic [FW-1:0]    preg_q,
    output logic [PW-1:0]    wval_q
);

    seq_state_e state_q, state_d;
    logic       start_rd, start_wr;

    assign start_rd = we && (idx == IDX_W'(IDX_CMD)) && rd_bit_new && !rd_bit_old;
    assign start_wr = we && (idx == IDX_W'(IDX_WDATA));

    // next-state selection: every state leaves on a new command or on done
    always_comb begin
        unique case (state_q)
            S_IDLE, S_READ, S_WRITE: begin
                if (start_rd)      state_d = S_READ;
                else if (start_wr) state_d = S_WRITE;
                else               state_d = S_IDLE;
            end
            default:               state_d = S_IDLE;
        endcase
    end

    // state register and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            preg_q  <= '0;
            wval_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start_rd || start_wr) preg_q <= preg_in;
            if (start_wr)             wval_q <= wr_val;
        end
    end

    // outputs
    always_comb begin
        rd_go = 1'b0;
        wr_go = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_READ:  rd_go = 1'b1;
            S_WRITE: wr_go = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/phy_model.sv
module phy_model #(
    parameter int unsigned  FW         = 5,
    parameter int unsigned  PW         = 16,
    parameter logic [PW-1:0] STAT_CAPS = 16'h7809,
    parameter int unsigned  LINK_BIT   = 2,
    parameter logic [PW-1:0] CTRL_CLR  = 16'h8100,
    parameter int unsigned  FIX_REG    = 10,
    parameter logic [PW-1:0] FIX_VAL   = 16'h1800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_up,
    input  logic          wr_go,
    input  logic [FW-1:0] sel,
    input  logic [PW-1:0] wval,
    output logic [PW-1:0] rd_val,
    output logic [PW-1:0] ctrl_o
);

    localparam logic [FW-1:0] REG_CTRL = FW'(0);
    localparam logic [FW-1:0] REG_STAT = FW'(1);
    localparam logic [FW-1:0] REG_FIX  = FW'(FIX_REG);

    logic [PW-1:0] ctrl_q;
    logic [PW-1:0] stat_w;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_go && sel == REG_CTRL)
            ctrl_q <= wval & ~CTRL_CLR;
    end

    always_comb begin
        stat_w           = STAT_CAPS;
        stat_w[LINK_BIT] = link_up;
    end

    always_comb begin
        unique case (sel)
            REG_CTRL: rd_val = ctrl_q;
            REG_STAT: rd_val = stat_w;
            REG_FIX:  rd_val = FIX_VAL;
            default:  rd_val = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/phy_mgmt_front.sv
module phy_mgmt_front
    import phy_mgmt_pkg::*;
#(
    parameter int unsigned NREG = 8,
    parameter int unsigned DW   = 32,
    parameter int unsigned PW   = 16,
    parameter int unsigned FW   = 5,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             link_up
);

    logic [NREG-1:0][DW-1:0] regs;
    logic                    rd_go, wr_go;
    logic [FW-1:0]           preg;
    logic [PW-1:0]           wval;
    logic [PW-1:0]           phy_rd;
    logic [PW-1:0]           phy_ctrl;
    logic                    link_q;
    logic [DW-1:0]           ev_set;

    logic [DW-1:0] cmd_reg, addr_reg, wdat_reg, stat_reg, event_reg;
    assign cmd_reg   = regs[IDX_CMD];
    assign addr_reg  = regs[IDX_ADDR];
    assign wdat_reg  = regs[IDX_WDATA];
    assign stat_reg  = regs[IDX_RDATA];
    assign event_reg = regs[IDX_EVENT];

    always_ff @(posedge clk) begin
        if (!rst_n) link_q <= link_up;
        else        link_q <= link_up;
    end
    assign ev_set = {{(DW-1){1'b0}}, link_q ^ link_up};

    mgmt_regbank #(.NREG(NREG), .DW(DW), .KEEP_W(PW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .idx      (bus_idx),
        .wdata    (bus_wdata),
        .ld_en    (rd_go),
        .ld_val   ({{(DW-PW){1'b0}}, phy_rd}),
        .set_bits (ev_set),
        .regs_o   (regs)
    );

    mgmt_seq #(.IDX_W(IDX_W), .FW(FW), .PW(PW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (bus_we),
        .idx        (bus_idx),
        .rd_bit_new (bus_wdata[0]),
        .rd_bit_old (cmd_reg[0]),
        .wr_val     (bus_wdata[PW-1:0]),
        .preg_in    (addr_reg[FW-1:0]),
        .rd_go      (rd_go),
        .wr_go      (wr_go),
        .preg_q     (preg),
        .wval_q     (wval)
    );

    phy_model #(.FW(FW), .PW(PW)) u_phy (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .wr_go   (wr_go),
        .sel     (preg),
        .wval    (wval),
        .rd_val  (phy_rd),
        .ctrl_o  (phy_ctrl)
    );

    assign bus_rdata = regs[bus_idx];

endmodule

// File: rtl/phy_mgmt_front_chk.sv
module phy_mgmt_front_chk #(
    parameter int unsigned DW = 32,
    parameter int unsigned PW = 16,
    parameter int unsigned FW = 5,
    parameter int unsigned IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [IDX_W-1:0] bus_idx,
    input logic [DW-1:0]    bus_wdata,
    input logic             link_up,
    input logic             rd_go,
    input logic             wr_go,
    input logic [FW-1:0]    preg,
    input logic [DW-1:0]    cmd_reg,
    input logic [DW-1:0]    wdat_reg,
    input logic [DW-1:0]    stat_reg,
    input logic [DW-1:0]    event_reg,
    input logic [PW-1:0]    phy_ctrl,
    input logic             link_q
);

    p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_W'(0) && bus_wdata[0] && cmd_reg[0]) |=> !rd_go);

    p_edge_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_W'(0) && bus_wdata[0] && !cmd_reg[0]) |=> rd_go);

    p_status_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(stat_reg));

    p_write_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_idx == IDX_W'(2)) |=> (wr_go && wdat_reg[DW-1:PW] == '0));

    p_ctrl_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_ctrl[15] && !phy_ctrl[8]);

    p_link_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && preg == FW'(1)) |=> (stat_reg[2] == $past(link_up)));

    p_event_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q != link_up) |=> event_reg[0]);

    p_one_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_go, wr_go}));

endmodule

bind phy_mgmt_front phy_mgmt_front_chk #(.DW(DW), .PW(PW), .FW(FW), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .link_up   (link_up),
    .rd_go     (rd_go),
    .wr_go     (wr_go),
    .preg      (preg),
    .cmd_reg   (cmd_reg),
    .wdat_reg  (wdat_reg),
    .stat_reg  (stat_reg),
    .event_reg (event_reg),
    .phy_ctrl  (phy_ctrl),
    .link_q    (link_q)
);

// File: tb/phy_mgmt_front_tb.sv
module phy_mgmt_front_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        link_up = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit model_on = 0;

    always #2 clk = ~clk;   // 250 MHz

    phy_mgmt_front u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .link_up   (link_up)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_reg [8];
    logic [15:0] m_phy_ctrl;
    bit          m_pend_rd, m_pend_wr;
    int          m_pend_num;
    logic [15:0] m_pend_data;
    logic        m_link_prev;

    function automatic logic [15:0] phy_word(int num, logic lnk, logic [15:0] pc);
        if (num == 0)  return pc;
        if (num == 1)  return 16'h7809 | (lnk ? 16'h0004 : 16'h0000);
        if (num == 10) return 16'h1800;
        return 16'h0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_reg[k]) m_reg[k] = '0;
            m_phy_ctrl = '0;
            m_pend_rd = 0;
            m_pend_wr = 0;
            m_pend_num = 0;
            m_pend_data = '0;
            m_link_prev = link_up;
        end else begin
            logic [31:0] clr;
            if (m_pend_rd) m_reg[3] = {16'h0, phy_word(m_pend_num, link_up, m_phy_ctrl)};
            if (m_pend_wr && m_pend_num == 0) m_phy_ctrl = m_pend_data & ~16'h8100;
            m_pend_rd = 0;
            m_pend_wr = 0;
            clr = (bus_we && bus_idx == 3'd6) ? bus_wdata : 32'h0;
            m_reg[6] = (m_reg[6] & ~clr) | {31'h0, m_link_prev != link_up};
            if (bus_we) begin
                case (bus_idx)
                    3'd0: begin
                        if (bus_wdata[0] && !m_reg[0][0]) begin
                            m_pend_rd = 1;
                            m_pend_num = int'(m_reg[1][4:0]);
                        end
                        m_reg[0] = bus_wdata;
                    end
                    3'd1: m_reg[1] = bus_wdata;
                    3'd2: begin
                        m_reg[2] = bus_wdata & 32'h0000_FFFF;
                        m_pend_wr = 1;
                        m_pend_num = int'(m_reg[1][4:0]);
                        m_pend_data = bus_wdata[15:0];
                    end
                    3'd4: m_reg[4] = bus_wdata;
                    3'd5: m_reg[5] = bus_wdata;
                    default: ;
                endcase
            end
            m_link_prev = link_up;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(logic [2:0] i);
        case (i)
            3'd0: return "R2 command";
            3'd1: return "R4 address";
            3'd2: return "R5 write-data";
            3'd3: return "R3 read-data";
            3'd4, 3'd5: return "R8 generic";
            3'd6: return "R9 event";
            default: return "R10 reserved";
        endcase
    endfunction

    // compare against model, then drive the next bus op
    task automatic op(input bit we, input int idx, input logic [31:0] d);
        @(negedge clk);
        if (model_on) check(tag_of(bus_idx), bus_rdata, m_reg[bus_idx]);
        bus_we = we;
        bus_idx = 3'(idx);
        bus_wdata = d;
    endtask

    task automatic expect_reg(input int idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        if (model_on) check(tag_of(bus_idx), bus_rdata, m_reg[bus_idx]);
        bus_we = 0;
        bus_idx = 3'(idx);
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic phy_read(input logic [31:0] addr);
        op(1, 1, addr);
        op(1, 0, 32'h0);
        op(1, 0, 32'h1);
        op(0, 3, 32'h0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_on = 1;

        for (int i = 0; i < 8; i++) expect_reg(i, 32'h0, "R1 reset");

        // R3 fixed word, PHY address 31
        phy_read(32'h0000_1F0A);
        expect_reg(3, 32'h0000_1800, "R3 reg10");

        // R2 rewrite of a stored 1 starts nothing
        op(1, 1, 32'h0000_0001);
        op(1, 0, 32'h0000_0001);
        op(0, 3, 32'h0);
        expect_reg(3, 32'h0000_1800, "R2 no restart");
        expect_reg(0, 32'h0000_0001, "R2 command stored");

        // R7 link down then up
        phy_read(32'h0000_0001);
        expect_reg(3, 32'h0000_7809, "R7 link down");
        @(negedge clk);
        link_up = 1'b1;
        expect_reg(6, 32'h0000_0001, "R9 event set");
        op(1, 6, 32'h0);
        expect_reg(6, 32'h0000_0001, "R9 zero write");
        op(1, 6, 32'h1);
        expect_reg(6, 32'h0000_0000, "R9 cleared");
        phy_read(32'h0000_0701);
        expect_reg(3, 32'h0000_780D, "R7 link up");

        // R5 / R6 control write through PHY address 5, read via address 31 (R4)
        op(1, 1, 32'h0000_0500);
        op(1, 2, 32'h1234_FFFF);
        expect_reg(2, 32'h0000_FFFF, "R5 low half");
        phy_read(32'h0000_1F00);
        expect_reg(3, 32'h0000_7EFF, "R6 masked R4 addr ignored");

        // R6 write to another register ignored
        op(1, 1, 32'h0000_0001);
        op(1, 2, 32'h0000_0000);
        phy_read(32'h0000_0000);
        expect_reg(3, 32'h0000_7EFF, "R6 other reg ignored");
        phy_read(32'h0000_0003);
        expect_reg(3, 32'h0000_0000, "R3 unanswered reg");

        // R8 generic registers
        op(1, 4, 32'hA5A5_5A5A);
        op(1, 5, 32'hDEAD_BEEF);
        expect_reg(4, 32'hA5A5_5A5A, "R8 read-write");
        expect_reg(5, 32'hDEAD_BEEF, "R8 write-only");

        // R10 read-only ignore writes
        op(1, 3, 32'hFFFF_FFFF);
        op(1, 7, 32'hFFFF_FFFF);
        expect_reg(3, 32'h0000_0000, "R10 read-data");
        expect_reg(7, 32'h0000_0000, "R10 reserved");

        // R11 back-to-back write then read
        op(1, 1, 32'h0000_0000);
        op(1, 0, 32'h0);
        op(1, 2, 32'h0000_0101);
        op(1, 0, 32'h1);
        op(0, 3, 32'h0);
        expect_reg(3, 32'h0000_0001, "R11 back-to-back");

        // random phase, model compared every clock
        for (int n = 0; n < 600; n++) begin
            int sel = $urandom_range(0, 7);
            logic [31:0] d = $urandom();
            if (sel == 1) begin
                int pick = $urandom_range(0, 3);
                d[4:0] = (pick == 0) ? 5'd0 : (pick == 1) ? 5'd1 : (pick == 2) ? 5'd10 : d[4:0];
            end
            if ($urandom_range(0, 15) == 0) link_up = ~link_up;
            op($urandom_range(0, 3) != 0, sel, d);
        end
        op(0, 0, 32'h0);

        done = 1;
        summary();
        $finish;
    end

endmodule